// File: doc/BRIEF.md
# TLB Invalidation Sequencer

This block carries out the maintenance commands that retire translation entries by marking them as not-exist. A command is an invalidate with a selection code, a clear by index or a flush by index. It comes with an address-space identifier, a virtual address and an entry index. After an accepted start strobe the block walks the entries it has to consider, one per cycle. It drives the index of the entry under inspection to the entry store and reads that entry's global flag, ASID, VPN and page mask back on its inputs. In any cycle where the entry meets the command's selection rule, it raises a kill strobe, and the store sets the not-exist bit of the presented index on that clock edge.

The entry store is external. It holds a set-associative part of WAYS x SETS entries at indices way*SETS+line, followed by ASSOC fully associative entries. An unsupported command raises a one-cycle illegal flag and touches nothing. Every accepted legal command ends with a one-cycle done pulse.

Top module: `tlbinv_seq`

## Requirements
- R1: While reset is held and just after it is released, busy_o, done_o, illegal_o and kill_o are all 0.
- R2: kind_i = 0 selects an invalidate by op_i. Codes 0 and 1 visit every entry from 0 to TOTAL-1 in ascending order, one per cycle starting the cycle after start, and kill each one.
- R3: Code 2 kills only entries whose global flag is 1. Code 3 kills only entries whose global flag is 0.
- R4: Code 4 kills the non-global entries whose ASID equals asid_i.
- R5: Code 5 kills the non-global entries that match asid_i and whose VPN equals va_i ANDed with a mask clearing bits [PAIR_LSB-1:0] and ANDed with the inverse of the entry's page mask. Code 6 applies the same VPN test but accepts an entry that is either global or ASID-matching.
- R6: An invalidate code above 6, or kind_i = 3, pulses illegal_o for one cycle, one cycle after start. No walk and no kill follow.
- R7: kind_i = 1 is a clear and kind_i = 2 is a flush. With index_i below WAYS*SETS, the walk visits entries way*SETS + (index_i mod SETS) for way 0 up to WAYS-1, one per cycle.
- R8: For a clear or flush with index_i from WAYS*SETS to TOTAL-1, the walk visits every associative entry in ascending order.
- R9: A clear kills the visited non-global entries that match asid_i. A flush kills every visited entry.
- R10: A clear or flush with index_i at or above TOTAL pulses done_o one cycle after start, with no walk and no kill.
- R11: A start strobe that arrives while busy_o is 1 is ignored. The walk in progress and its kills are unchanged.
- R12: done_o is 1 for exactly the one cycle after the last visited entry, and busy_o is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| kind_i | input | 2 | 0 invalidate, 1 clear, 2 flush, 3 reserved |
| op_i | input | 5 | Invalidate selection code |
| asid_i | input | ASID_W | Address-space identifier for the command |
| va_i | input | VA_W | Virtual address for the VPN-matching codes |
| index_i | input | IDX_W | Entry index for clear and flush |
| ent_global_i | input | 1 | Global flag of the entry at scan_idx_o |
| ent_asid_i | input | ASID_W | ASID of the entry at scan_idx_o |
| ent_vpn_i | input | VA_W | Stored VPN of the entry at scan_idx_o |
| ent_pgmask_i | input | VA_W | Page mask of the entry at scan_idx_o |
| scan_idx_o | output | IDX_W | Index of the entry under inspection |
| kill_o | output | 1 | Set not-exist on the entry at scan_idx_o |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| illegal_o | output | 1 | One-cycle unsupported-command pulse |

## Verification
The bench aims at the edges of the index decode: the last set-associative line, the first associative entry, and the values exactly at and above the total entry count. A design that mixed these up would walk the wrong entries, kill associative entries on a line clear, or hang on an out-of-range index. It mixes global and ASID-matched entries with several page sizes so that codes 5 and 6 see both masked hits and near misses; a wrong VPN mask or a swapped global condition would leave entries alive or kill innocent ones. It also fires a second start in the middle of a walk and issues unsupported codes. A design that restarted the walk would change the visit order, and one that went ahead on a bad code would alter the store or miss the illegal pulse.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    localparam int OP_W     = 5;
    localparam int OP_MAXOK = 6;

    typedef enum logic [1:0] {
        KIND_INV   = 2'd0,
        KIND_CLEAR = 2'd1,
        KIND_FLUSH = 2'd2,
        KIND_RSVD  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        SEL_ALL       = 3'd0,
        SEL_GLOBAL    = 3'd1,
        SEL_LOCAL     = 3'd2,
        SEL_ASID      = 3'd3,
        SEL_ASID_VA   = 3'd4,
        SEL_SHARED_VA = 3'd5
    } sel_rule_e;

    // Selection rule for a legal invalidate code
    function automatic sel_rule_e op_to_rule(input logic [OP_W-1:0] op);
        case (op)
            5'd2:    return SEL_GLOBAL;
            5'd3:    return SEL_LOCAL;
            5'd4:    return SEL_ASID;
            5'd5:    return SEL_ASID_VA;
            5'd6:    return SEL_SHARED_VA;
            default: return SEL_ALL;
        endcase
    endfunction

endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
    import tlbinv_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int SETS  = 256,
    parameter int ASSOC = 64,
    localparam int TOTAL  = WAYS * SETS + ASSOC,
    localparam int IDX_W  = $clog2(TOTAL)
) (
    input  logic [1:0]       kind_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [IDX_W-1:0] index_i,
    output logic             legal_o,
    output logic             empty_o,
    output sel_rule_e        rule_o,
    output logic [IDX_W-1:0] first_o,
    output logic [IDX_W-1:0] step_o,
    output logic [IDX_W-1:0] last_o
);
    localparam int LINE_W = $clog2(SETS);
    localparam logic [IDX_W-1:0] SA_BASE   = IDX_W'(WAYS * SETS);
    localparam logic [IDX_W-1:0] END_IDX   = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] TOTAL_L   = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] LINE_SPAN = IDX_W'((WAYS - 1) * SETS);
    localparam logic [IDX_W-1:0] WAY_STEP  = IDX_W'(SETS);

    logic [IDX_W-1:0] line_idx;
    assign line_idx = IDX_W'(index_i[LINE_W-1:0]);

    always_comb begin
        legal_o = 1'b1;
        empty_o = 1'b0;
        rule_o  = SEL_ALL;
        first_o = '0;
        step_o  = IDX_W'(1);
        last_o  = END_IDX;
        case (cmd_kind_e'(kind_i))
            KIND_INV: begin
                if (op_i > OP_W'(OP_MAXOK)) legal_o = 1'b0;
                else                        rule_o  = op_to_rule(op_i);
            end
            KIND_CLEAR, KIND_FLUSH: begin
                rule_o = (cmd_kind_e'(kind_i) == KIND_CLEAR) ? SEL_ASID : SEL_ALL;
                if (index_i < SA_BASE) begin
                    first_o = line_idx;
                    step_o  = WAY_STEP;
                    last_o  = line_idx + LINE_SPAN;
                end else if (index_i < TOTAL_L) begin
                    first_o = SA_BASE;
                end else begin
                    empty_o = 1'b1;
                end
            end
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
#(
    parameter int ASID_W   = 10,
    parameter int VA_W     = 48,
    parameter int PAIR_LSB = 13
) (
    input  sel_rule_e         rule_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic              ent_global_i,
    input  logic [ASID_W-1:0] ent_asid_i,
    input  logic [VA_W-1:0]   ent_vpn_i,
    input  logic [VA_W-1:0]   ent_pgmask_i,
    output logic              hit_o
);
    localparam logic [VA_W-1:0] PAIR_MASK = {{(VA_W-PAIR_LSB){1'b1}}, {PAIR_LSB{1'b0}}};

    logic asid_eq, vpn_eq;
    assign asid_eq = (ent_asid_i == asid_i);
    assign vpn_eq  = ((va_i & PAIR_MASK & ~ent_pgmask_i) == ent_vpn_i);

    always_comb begin
        case (rule_i)
            SEL_ALL:       hit_o = 1'b1;
            SEL_GLOBAL:    hit_o = ent_global_i;
            SEL_LOCAL:     hit_o = !ent_global_i;
            SEL_ASID:      hit_o = !ent_global_i && asid_eq;
            SEL_ASID_VA:   hit_o = !ent_global_i && asid_eq && vpn_eq;
            SEL_SHARED_VA: hit_o = (ent_global_i || asid_eq) && vpn_eq;
            default:       hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             legal_i,
    input  logic             empty_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [IDX_W-1:0] step_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] cur_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             illegal_o
);
    logic [IDX_W-1:0] step_q, last_q;

    assign accept_o = start_i && !busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            cur_o     <= '0;
            step_q    <= '0;
            last_q    <= '0;
        end else begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            if (accept_o) begin
                if (!legal_i) begin
                    illegal_o <= 1'b1;
                end else if (empty_i) begin
                    done_o <= 1'b1;
                end else begin
                    busy_o <= 1'b1;
                    cur_o  <= first_i;
                    step_q <= step_i;
                    last_q <= last_i;
                end
            end else if (busy_o) begin
                if (cur_o == last_q) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cur_o <= cur_o + step_q;
                end
            end
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && cur_o != last_q) |=> (busy_o && cur_o == $past(cur_o) + $past(step_q))); // R11
    AST_WALK_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cur_o == last_q) |=> (!busy_o && done_o)); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o); // R12
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!busy_o && !done_o)); // R6
endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq
    import tlbinv_pkg::*;
#(
    parameter int WAYS     = 8,
    parameter int SETS     = 256,
    parameter int ASSOC    = 64,
    parameter int ASID_W   = 10,
    parameter int VA_W     = 48,
    parameter int PAIR_LSB = 13,
    localparam int TOTAL   = WAYS * SETS + ASSOC,
    localparam int IDX_W   = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [4:0]        op_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [IDX_W-1:0]  index_i,
    input  logic              ent_global_i,
    input  logic [ASID_W-1:0] ent_asid_i,
    input  logic [VA_W-1:0]   ent_vpn_i,
    input  logic [VA_W-1:0]   ent_pgmask_i,
    output logic [IDX_W-1:0]  scan_idx_o,
    output logic              kill_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o
);
    logic             dec_legal, dec_empty, accept, hit;
    sel_rule_e        dec_rule, rule_q;
    logic [IDX_W-1:0] dec_first, dec_step, dec_last;
    logic [ASID_W-1:0] asid_q;
    logic [VA_W-1:0]   va_q;

    tlbinv_decode #(.WAYS(WAYS), .SETS(SETS), .ASSOC(ASSOC)) u_decode (
        .kind_i (kind_i),  .op_i   (op_i),     .index_i(index_i),
        .legal_o(dec_legal), .empty_o(dec_empty), .rule_o(dec_rule),
        .first_o(dec_first), .step_o (dec_step),  .last_o(dec_last)
    );

    tlbinv_walker #(.IDX_W(IDX_W)) u_walker (
        .clk(clk), .rst(rst), .start_i(start_i),
        .legal_i(dec_legal), .empty_i(dec_empty),
        .first_i(dec_first), .step_i(dec_step), .last_i(dec_last),
        .accept_o(accept), .cur_o(scan_idx_o), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rule_q <= SEL_ALL;
            asid_q <= '0;
            va_q   <= '0;
        end else if (accept) begin
            rule_q <= dec_rule;
            asid_q <= asid_i;
            va_q   <= va_i;
        end
    end

    tlbinv_match #(.ASID_W(ASID_W), .VA_W(VA_W), .PAIR_LSB(PAIR_LSB)) u_match (
        .rule_i(rule_q), .asid_i(asid_q), .va_i(va_q),
        .ent_global_i(ent_global_i), .ent_asid_i(ent_asid_i),
        .ent_vpn_i(ent_vpn_i), .ent_pgmask_i(ent_pgmask_i), .hit_o(hit)
    );

    assign kill_o = busy_o && hit;

    AST_KILL_IN_WALK: assert property (@(posedge clk) disable iff (rst)
        kill_o |-> busy_o); // R2
    AST_GLOBAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (kill_o && rule_q == SEL_GLOBAL) |-> ent_global_i); // R3
    AST_LOCAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (kill_o && (rule_q == SEL_LOCAL || rule_q == SEL_ASID || rule_q == SEL_ASID_VA)) |-> !ent_global_i); // R4
    AST_ASID_MATCH: assert property (@(posedge clk) disable iff (rst)
        (kill_o && rule_q == SEL_ASID) |-> (ent_asid_i == asid_q)); // R9
endmodule

// File: tb/test_tlbinv_seq.sv
module test_tlbinv_seq;
    localparam int WAYS = 4, SETS = 16, ASSOC = 8;
    localparam int TOTAL = WAYS * SETS + ASSOC;
    localparam int SA = WAYS * SETS;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [47:0] PAIR = 48'hFFFF_FFFF_E000;

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
    logic [1:0] kind_i = '0;
    logic [4:0] op_i = '0;
    logic [9:0] asid_i = '0;
    logic [47:0] va_i = '0;
    logic [IDX_W-1:0] index_i = '0;
    logic ent_global_i;
    logic [9:0] ent_asid_i;
    logic [47:0] ent_vpn_i, ent_pgmask_i;
    logic [IDX_W-1:0] scan_idx_o;
    logic kill_o, busy_o, done_o, illegal_o;

    bit          m_g    [TOTAL];
    logic [9:0]  m_asid [TOTAL];
    logic [47:0] m_vpn  [TOTAL];
    logic [47:0] m_mask [TOTAL];
    bit          m_ne   [TOTAL];
    bit          old_ne [TOTAL];

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tlbinv_seq #(.WAYS(WAYS), .SETS(SETS), .ASSOC(ASSOC)) i_tlbinv_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .op_i(op_i),
        .asid_i(asid_i), .va_i(va_i), .index_i(index_i),
        .ent_global_i(ent_global_i), .ent_asid_i(ent_asid_i),
        .ent_vpn_i(ent_vpn_i), .ent_pgmask_i(ent_pgmask_i),
        .scan_idx_o(scan_idx_o), .kill_o(kill_o), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    wire in_rng = int'(scan_idx_o) < TOTAL;
    assign ent_global_i = in_rng ? m_g[scan_idx_o]    : 1'b0;
    assign ent_asid_i   = in_rng ? m_asid[scan_idx_o] : '0;
    assign ent_vpn_i    = in_rng ? m_vpn[scan_idx_o]  : '0;
    assign ent_pgmask_i = in_rng ? m_mask[scan_idx_o] : '0;

    always @(posedge clk) if (kill_o && in_rng) m_ne[scan_idx_o] <= 1'b1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_store();
        for (int i = 0; i < TOTAL; i++) begin
            int ps;
            logic [47:0] r;
            ps = ($urandom % 3 == 0) ? 12 : (($urandom % 2 == 0) ? 14 : 21);
            r  = {$urandom, $urandom};
            m_g[i]    = ($urandom % 4 == 0);
            m_asid[i] = 10'(1 + $urandom % 3);
            m_mask[i] = (48'd1 << (ps + 1)) - 48'd1;
            m_vpn[i]  = r & PAIR & ~m_mask[i];
            m_ne[i]   = ($urandom % 5 == 0);
        end
    endtask

    function automatic bit exp_sel(int kind, int op, logic [9:0] asid, logic [47:0] va, int i);
        bit g, am, vh;
        g  = m_g[i];
        am = (m_asid[i] == asid);
        vh = ((va & PAIR & ~m_mask[i]) == m_vpn[i]);
        if (kind == 1) return !g && am;
        if (kind == 2) return 1'b1;
        case (op)
            0, 1: return 1'b1;
            2: return g;
            3: return !g;
            4: return !g && am;
            5: return !g && am && vh;
            6: return (g || am) && vh;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_cmd(input int kind, input int op, input logic [9:0] asid,
                           input logic [47:0] va, input int index, input string req,
                           input bit inject);
        int first, step, count, n, bad;
        bit illegal, hit_walk;
        illegal = (kind == 3) || (kind == 0 && op > 6);
        first = 0; step = 1; count = TOTAL;
        if (kind == 1 || kind == 2) begin
            if (index < SA) begin first = index % SETS; step = SETS; count = WAYS; end
            else if (index < TOTAL) begin first = SA; count = ASSOC; end
            else count = 0;
        end
        if (illegal) count = 0;
        for (int i = 0; i < TOTAL; i++) old_ne[i] = m_ne[i];
        @(negedge clk);
        kind_i = 2'(kind); op_i = 5'(op); asid_i = asid; va_i = va;
        index_i = IDX_W'(index); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (illegal) begin
            check(illegal_o === 1'b1 && busy_o === 1'b0, "R6 illegal pulse", illegal_o, 1);
            @(negedge clk);
            check(illegal_o === 1'b0 && busy_o === 1'b0, "R6 illegal clears", illegal_o, 0);
        end else begin
            n = 0; bad = 0;
            while (busy_o && n < 1000) begin
                if (int'(scan_idx_o) != first + n * step) bad++;
                if (inject && n == 2) begin
                    kind_i = 2'd2; index_i = '0; start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
                n++;
            end
            check(bad == 0, {req, " visit order"}, bad, 0);
            check(n == count, {req, " visit count"}, n, count);
            check(done_o === 1'b1, "R12 done after walk", done_o, 1);
            @(negedge clk);
            check(done_o === 1'b0, "R12 done one cycle", done_o, 0);
        end
        bad = 0;
        for (int i = 0; i < TOTAL; i++) begin
            hit_walk = 1'b0;
            for (int k = 0; k < count; k++) if (first + k * step == i) hit_walk = 1'b1;
            if (m_ne[i] != (old_ne[i] | (hit_walk && exp_sel(kind, op, asid, va, i)))) bad++;
        end
        check(bad == 0, {req, " store state"}, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] va;
        int j;
        void'($urandom(32'd1234));
        fill_store();
        repeat (3) @(negedge clk);
        check({busy_o, done_o, illegal_o, kill_o} === 4'b0, "R1 in reset", {busy_o, done_o, illegal_o, kill_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({busy_o, done_o, illegal_o, kill_o} === 4'b0, "R1 after reset", {busy_o, done_o, illegal_o, kill_o}, 0);

        fill_store(); run_cmd(0, 0, 10'd1, 48'd0, 0, "R2 op0", 1'b0);
        fill_store(); run_cmd(0, 1, 10'd2, 48'd0, 0, "R2 op1", 1'b0);
        fill_store(); run_cmd(0, 2, 10'd1, 48'd0, 0, "R3 op2", 1'b0);
        fill_store(); run_cmd(0, 3, 10'd1, 48'd0, 0, "R3 op3", 1'b0);
        fill_store(); run_cmd(0, 4, 10'd2, 48'd0, 0, "R4 op4", 1'b0);
        for (int t = 0; t < 4; t++) begin
            fill_store();
            j = $urandom % TOTAL;
            va = m_vpn[j] | ({$urandom, $urandom} & m_mask[j] & 48'h1FFF_FFFF);
            run_cmd(0, 5 + (t % 2), m_asid[j], va, 0, "R5 va match", 1'b0);
        end
        fill_store(); run_cmd(0, 7, 10'd1, 48'd0, 0, "R6 op7", 1'b0);
        fill_store(); run_cmd(0, 31, 10'd1, 48'd0, 0, "R6 op31", 1'b0);
        fill_store(); run_cmd(3, 0, 10'd1, 48'd0, 0, "R6 kind3", 1'b0);
        fill_store(); run_cmd(1, 0, 10'd2, 48'd0, 5, "R7 clear line", 1'b0);
        fill_store(); run_cmd(2, 0, 10'd2, 48'd0, SA - 1, "R7 flush last line", 1'b0);
        fill_store(); run_cmd(1, 0, 10'd3, 48'd0, SA, "R8 clear assoc", 1'b0);
        fill_store(); run_cmd(2, 0, 10'd1, 48'd0, TOTAL - 1, "R8 flush assoc", 1'b0);
        fill_store(); run_cmd(1, 0, 10'd1, 48'd0, SA + 3, "R9 clear asid", 1'b0);
        fill_store(); run_cmd(1, 0, 10'd1, 48'd0, TOTAL, "R10 index at end", 1'b0);
        fill_store(); run_cmd(2, 0, 10'd1, 48'd0, (1 << IDX_W) - 1, "R10 index max", 1'b0);
        fill_store(); run_cmd(0, 4, 10'd1, 48'd0, 0, "R11 start while busy", 1'b1);
        fill_store(); run_cmd(1, 0, 10'd2, 48'd0, 9, "R11 restart on clear", 1'b1);

        for (int t = 0; t < 25; t++) begin
            int kind, op, idx;
            fill_store();
            kind = $urandom % 4;
            op   = $urandom % 9;
            idx  = $urandom % (1 << IDX_W);
            j    = $urandom % TOTAL;
            va   = m_vpn[j] | ({$urandom, $urandom} & m_mask[j] & 48'h1FFF_FFFF);
            run_cmd(kind, op, m_asid[j], va, idx, "R9 random", 1'b0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule